// File: doc/BRIEF.md
# Key-protected flash command controller

This block sits between a register bus and the command port of an on-chip flash array. Software loads a target address and a data word into two plain registers. It then writes a control register whose upper half-word must hold an unlock key and whose low bits choose one of three operations: word program, page erase or mass erase. A control write that carries the right key and exactly one command bit, and that arrives while nothing is running, is accepted. The block copies the address and data into operand registers and sends a one-cycle start pulse to the array. The pulse carries the operation code and the copied operands.

While an operation runs, the command bit that started it reads back as 1 and acts as a busy flag. The array answers with a done pulse, and the busy flag clears in the cycle after the controller samples that pulse. Control writes that arrive during this time are dropped. Address and data register writes during this time change only the software-visible registers and leave the running operation's operands alone.

Top module: `fcmd_ctrl`

## Requirements
- R1: After reset, the address, data and control registers all read 0, `fl_start` is low, and no operation starts when reset is released.
- R2: The address register (bus offset 0x0) and the data register (bus offset 0x4) are 32-bit read/write registers that read back the last value written to them.
- R3: A control write (bus offset 0x8) whose bits 31:16 differ from 0xA442 is ignored entirely. No start pulse follows and the command bits stay unchanged.
- R4: A read of the control register returns 0 in bits 31:3 (the key field and the reserved bits). Bits 2:0 hold the busy flags.
- R5: A control write is accepted when it is keyed, sets exactly one of bit 0 (program, `fl_op`=01), bit 1 (page erase, `fl_op`=10) or bit 2 (mass erase, `fl_op`=11), and arrives while idle. In the cycle after the write, `fl_start` is high, `fl_op` carries the code, and `fl_addr`/`fl_data` equal the address and data registers as they were at the write. That command bit then reads 1.
- R6: A keyed control write that sets two or more of bits 2:0 is ignored: no start pulse, and the command bits stay unchanged.
- R7: While any command bit is 1, a keyed control write starts nothing. Address and data register writes do not change `fl_addr` or `fl_data`.
- R8: When `fl_done` is sampled high while a command bit is 1, all command bits read 0 from the next cycle on. `fl_done` while idle has no effect.
- R9: A keyed control write with bits 2:0 all zero has no effect.
- R10: `fl_start` is high for exactly one cycle per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_ofs | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the selected register |
| fl_start | output | 1 | One-cycle start pulse toward the flash array |
| fl_op | output | 2 | Operation code: 01 program, 10 page erase, 11 mass erase |
| fl_addr | output | 32 | Latched target address |
| fl_data | output | 32 | Latched program data |
| fl_done | input | 1 | Completion pulse from the flash array |

## Verification
Control writes are generated at random with the key mostly correct and the command field drawn from all eight values. This separates acceptance of a single bit from rejection of zero bits and of two or more bits, and from rejection of a wrong key. Address and data writes are mixed with done pulses that come after random delays, so some control writes and operand writes land while an operation is still running. These cases show whether the latched operands and the busy gating hold. Directed cases add done pulses while idle, back-to-back runs of each operation, and a wrong key that carries a valid command bit.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PROG = 2'b01,
    OP_PAGE = 2'b10,
    OP_MASS = 2'b11
  } fl_op_e;

  localparam int unsigned NUM_CMD = 3;
  localparam int unsigned KEY_W   = 16;

endpackage

// File: rtl/fcmd_rst_sync.sv
module fcmd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/fcmd_regs.sv
module fcmd_regs
  import fcmd_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned OFS_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [OFS_W-1:0]   bus_ofs,
  input  logic [DW-1:0]      bus_wdata,
  input  logic [NUM_CMD-1:0] status,
  output logic [DW-1:0]      addr_q,
  output logic [DW-1:0]      data_q,
  output logic [DW-1:0]      bus_rdata,
  output logic               ctrl_wr
);

  localparam logic [OFS_W-1:0] SEL_ADDR = OFS_W'(0);
  localparam logic [OFS_W-1:0] SEL_DATA = OFS_W'(4);
  localparam logic [OFS_W-1:0] SEL_CTRL = OFS_W'(8);

  logic          wr_any;
  logic          addr_en;
  logic          data_en;
  logic [DW-1:0] addr_d;
  logic [DW-1:0] data_d;

  always_comb begin
    wr_any  = bus_sel && bus_wr;
    addr_en = wr_any && (bus_ofs == SEL_ADDR);
    data_en = wr_any && (bus_ofs == SEL_DATA);
    ctrl_wr = wr_any && (bus_ofs == SEL_CTRL);
    addr_d  = addr_en ? bus_wdata : addr_q;
    data_d  = data_en ? bus_wdata : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (bus_ofs)
        SEL_ADDR: bus_rdata = addr_q;
        SEL_DATA: bus_rdata = data_q;
        SEL_CTRL: bus_rdata = {{(DW-NUM_CMD){1'b0}}, status};
        default:  bus_rdata = '0;
      endcase
    end
  end

  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_ofs == SEL_CTRL) |-> (bus_rdata[DW-1:NUM_CMD] == '0)); // R4

  AST_ADDR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(addr_q) && $stable(data_q)); // R2

endmodule

// File: rtl/fcmd_keychk.sv
module fcmd_keychk
  import fcmd_pkg::*;
#(
  parameter int unsigned     DW         = 32,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hA442
) (
  input  logic               ctrl_wr,
  input  logic [DW-1:0]      wdata,
  input  logic               busy_any,
  output logic               accept,
  output logic [NUM_CMD-1:0] acc_bits,
  output fl_op_e             acc_op
);

  logic [KEY_W-1:0]   key_f;
  logic [NUM_CMD-1:0] cmd_f;
  logic               key_ok;

  always_comb begin
    key_f  = wdata[DW-1 -: KEY_W];
    cmd_f  = wdata[NUM_CMD-1:0];
    key_ok = (key_f == UNLOCK_KEY);
    unique case (cmd_f)
      3'b001:  acc_op = OP_PROG;
      3'b010:  acc_op = OP_PAGE;
      3'b100:  acc_op = OP_MASS;
      default: acc_op = OP_NONE;
    endcase
    accept   = ctrl_wr && key_ok && (acc_op != OP_NONE) && !busy_any;
    acc_bits = cmd_f;
  end

  always_comb begin
    if (accept) begin
      AST_ACCEPT_ONEHOT: assert ($countones(acc_bits) == 1); // R6
    end
  end

endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [NUM_CMD-1:0] acc_bits,
  input  fl_op_e             acc_op,
  input  logic [DW-1:0]      addr_q,
  input  logic [DW-1:0]      data_q,
  input  logic               fl_done,
  output logic [NUM_CMD-1:0] busy,
  output logic               fl_start,
  output logic [1:0]         fl_op,
  output logic [DW-1:0]      fl_addr,
  output logic [DW-1:0]      fl_data
);

  logic [NUM_CMD-1:0] busy_q, busy_d;
  logic               start_q, start_d;
  fl_op_e             op_q, op_d;
  logic [DW-1:0]      opa_q, opa_d;
  logic [DW-1:0]      opd_q, opd_d;
  logic               busy_any;
  logic               finish;

  always_comb begin
    busy_any = |busy_q;
    finish   = busy_any && fl_done;
    busy_d   = busy_q;
    if (accept) begin
      busy_d = acc_bits;
    end else if (finish) begin
      busy_d = '0;
    end
    start_d = accept;
    op_d    = accept ? acc_op : op_q;
    opa_d   = accept ? addr_q : opa_q;
    opd_d   = accept ? data_q : opd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      start_q <= 1'b0;
      op_q    <= OP_NONE;
      opa_q   <= '0;
      opd_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      start_q <= start_d;
      op_q    <= op_d;
      opa_q   <= opa_d;
      opd_q   <= opd_d;
    end
  end

  assign busy     = busy_q;
  assign fl_start = start_q;
  assign fl_op    = op_q;
  assign fl_addr  = opa_q;
  assign fl_data  = opd_q;

  AST_BUSY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy_q)); // R5

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |=> !fl_start); // R10

  AST_START_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |-> (busy_q != '0)); // R5

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_start) |-> ($past(busy_q) == '0)); // R7

  AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_any && !fl_start) |-> ($stable(fl_addr) && $stable(fl_data) && $stable(fl_op))); // R7

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_any && fl_done) |=> (busy_q == '0)); // R8

  AST_IDLE_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_any && fl_done && !accept) |=> (busy_q == '0) && !fl_start); // R8

endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
  import fcmd_pkg::*;
#(
  parameter int unsigned      DW         = 32,
  parameter int unsigned      OFS_W      = 4,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hA442
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [OFS_W-1:0] bus_ofs,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             fl_start,
  output logic [1:0]       fl_op,
  output logic [DW-1:0]    fl_addr,
  output logic [DW-1:0]    fl_data,
  input  logic             fl_done
);

  logic               rst_n_s;
  logic [DW-1:0]      addr_q;
  logic [DW-1:0]      data_q;
  logic               ctrl_wr;
  logic [NUM_CMD-1:0] busy;
  logic               accept;
  logic [NUM_CMD-1:0] acc_bits;
  fl_op_e             acc_op;

  fcmd_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  fcmd_regs #(.DW(DW), .OFS_W(OFS_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_ofs   (bus_ofs),
    .bus_wdata (bus_wdata),
    .status    (busy),
    .addr_q    (addr_q),
    .data_q    (data_q),
    .bus_rdata (bus_rdata),
    .ctrl_wr   (ctrl_wr)
  );

  fcmd_keychk #(.DW(DW), .UNLOCK_KEY(UNLOCK_KEY)) i_keychk (
    .ctrl_wr  (ctrl_wr),
    .wdata    (bus_wdata),
    .busy_any (|busy),
    .accept   (accept),
    .acc_bits (acc_bits),
    .acc_op   (acc_op)
  );

  fcmd_seq #(.DW(DW)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .accept   (accept),
    .acc_bits (acc_bits),
    .acc_op   (acc_op),
    .addr_q   (addr_q),
    .data_q   (data_q),
    .fl_done  (fl_done),
    .busy     (busy),
    .fl_start (fl_start),
    .fl_op    (fl_op),
    .fl_addr  (fl_addr),
    .fl_data  (fl_data)
  );

  AST_RESET_NO_START: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> !fl_start); // R1

endmodule

// File: tb/test_fcmd_ctrl.sv
module test_fcmd_ctrl;

  localparam logic [15:0] KEY = 16'hA442;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_ofs;
  logic [31:0] bus_wdata, bus_rdata;
  logic        fl_start;
  logic [1:0]  fl_op;
  logic [31:0] fl_addr, fl_data;
  logic        fl_done;

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_addr, exp_data, exp_fa, exp_fd;
  logic [2:0]  exp_busy;

  always #5 clk = ~clk;

  fcmd_ctrl i_fcmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fl_start(fl_start), .fl_op(fl_op), .fl_addr(fl_addr),
    .fl_data(fl_data), .fl_done(fl_done)
  );

  function automatic logic [1:0] op_of(input logic [2:0] b);
    case (b)
      3'b001:  return 2'b01;
      3'b010:  return 2'b10;
      3'b100:  return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic takes(input logic [15:0] k, input logic [2:0] b, input logic [2:0] bz);
    return (k == KEY) && (op_of(b) != 2'b00) && (bz == 3'b000);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_sim();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic bus_write(input logic [3:0] ofs, input logic [31:0] val);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_ofs = ofs; bus_wdata = val;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] ofs, output logic [31:0] val);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_ofs = ofs;
    #1 val = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr_addr(input logic [31:0] v);
    logic [31:0] rd;
    bus_write(4'h0, v);
    exp_addr = v;
    if (exp_busy != 0) chk("R7 fl_addr held", fl_addr, exp_fa);
    bus_read(4'h0, rd);
    chk("R2 addr readback", rd, exp_addr);
  endtask

  task automatic wr_data(input logic [31:0] v);
    logic [31:0] rd;
    bus_write(4'h4, v);
    exp_data = v;
    if (exp_busy != 0) chk("R7 fl_data held", fl_data, exp_fd);
    bus_read(4'h4, rd);
    chk("R2 data readback", rd, exp_data);
  endtask

  task automatic ctrl_cmd(input logic [15:0] k, input logic [2:0] b, input logic [12:0] rsv);
    logic [31:0] rd;
    logic        acc;
    acc = takes(k, b, exp_busy);
    bus_write(4'h8, {k, rsv, b});
    chk("R3 R5 R6 R7 R9 start pulse", {31'b0, fl_start}, {31'b0, acc});
    if (acc) begin
      exp_busy = b; exp_fa = exp_addr; exp_fd = exp_data;
      chk("R5 op code", {30'b0, fl_op}, {30'b0, op_of(b)});
      chk("R5 addr operand", fl_addr, exp_fa);
      chk("R5 data operand", fl_data, exp_fd);
    end else if (exp_busy != 0) begin
      chk("R7 addr kept", fl_addr, exp_fa);
    end
    bus_read(4'h8, rd);
    chk("R4 R5 status read", rd, {29'b0, exp_busy});
    chk("R10 start drops", {31'b0, fl_start}, 32'd0);
  endtask

  task automatic pulse_done(input int lat);
    logic [31:0] rd;
    repeat (lat) @(negedge clk);
    fl_done = 1'b1;
    @(negedge clk);
    fl_done = 1'b0;
    exp_busy = 3'b000;
    chk("R8 no start on done", {31'b0, fl_start}, 32'd0);
    bus_read(4'h8, rd);
    chk("R8 busy cleared", rd, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_sim();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] seed;
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_ofs = 0; bus_wdata = 0; fl_done = 0;
    exp_addr = 0; exp_data = 0; exp_fa = 0; exp_fd = 0; exp_busy = 0;
    seed = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 start idle after reset", {31'b0, fl_start}, 32'd0);
    bus_read(4'h0, rd); chk("R1 addr reset", rd, 32'd0);
    bus_read(4'h4, rd); chk("R1 data reset", rd, 32'd0);
    bus_read(4'h8, rd); chk("R1 ctrl reset", rd, 32'd0);

    // Directed corner cases
    wr_addr(32'h0000_1F04);
    wr_data(32'hDEAD_BEEF);
    ctrl_cmd(16'hA443, 3'b001, 13'h0);          // R3 wrong key
    ctrl_cmd(KEY, 3'b000, 13'h1FFF);            // R9 zero bits
    ctrl_cmd(KEY, 3'b011, 13'h0);               // R6 two bits
    ctrl_cmd(KEY, 3'b111, 13'h0);               // R6 three bits
    pulse_done(1);                              // R8 done while idle
    ctrl_cmd(KEY, 3'b001, 13'h0);               // R5 program
    wr_addr(32'h1234_5678);                     // R7 during busy
    wr_data(32'h0BAD_F00D);
    ctrl_cmd(KEY, 3'b100, 13'h0);               // R7 command while busy
    pulse_done(2);
    ctrl_cmd(KEY, 3'b010, 13'h0);               // R5 page erase
    pulse_done(0);
    ctrl_cmd(KEY, 3'b100, 13'h0);               // R5 mass erase
    pulse_done(3);

    // Constrained random traffic
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom % 6;
      case (sel)
        0: wr_addr($urandom);
        1: wr_data($urandom);
        2, 3: ctrl_cmd(($urandom % 5 != 0) ? KEY : 16'($urandom), 3'($urandom), 13'($urandom));
        4: pulse_done($urandom % 4);
        default: begin
          bus_read(4'h8, rd);
          chk("R4 status read", rd, {29'b0, exp_busy});
        end
      endcase
    end
    finish_sim();
  end

endmodule